// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the sixteen architectural general registers of a processor core whose register storage changes with the execution mode. A 4-bit architectural index and a 5-bit mode value select one of 31 physical registers. The low eight indices and the program counter are the same in every mode. The fast-interrupt mode has its own copies of indices 8 to 14. Each of the other four exception modes has its own stack-pointer and link registers at indices 13 and 14. System mode uses the user storage. There are two combinational read ports and one write port. Each of these ports resolves its index through the current mode.

Each exception mode also has a saved-status register. It is read and written through a port that follows the current mode. A second, banked write port names its own target mode. Exception entry uses it to load the link register and the saved-status register of the mode being entered, in the same cycle in which the mode changes. The current-status register, decode and forwarding are outside this block.

Top module: `banked_regfile`

## Requirements
- R1: Indices 0 to 7 map to one shared physical register each, in every mode.
- R2: Indices 8 to 12 have a separate copy that is used only in FIQ mode (0x11). Every other mode uses the user copy.
- R3: Indices 13 and 14 have separate copies for the FIQ, supervisor, abort, undefined and IRQ modes. System mode (0x1F) shares them with user mode.
- R4: Mode encodings are user 0x10, FIQ 0x11, IRQ 0x12, supervisor 0x13, abort 0x17, undefined 0x1B and system 0x1F. Any other mode value is mapped as user.
- R5: Index 15 is one program-counter register, shared by all modes.
- R6: Each of the five exception modes has its own saved-status register. The saved-status port reads and writes the register of the current mode.
- R7: In user or system mode the saved-status port reads zero, and a write through it changes no saved-status register.
- R8: Reads are combinational. A read of a register that is being written in the same cycle returns the old value. The new value is visible after the clock edge.
- R9: The banked port writes the register of its own target mode, whatever the current mode is. The banked port wins over the normal port when both write the same register or the same saved-status register.
- R10: An active-low asynchronous reset clears every register and every saved-status register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 5 | Current execution mode |
| ra_idx_i | input | 4 | Read port A index |
| ra_data_o | output | DATA_W | Read port A data |
| rb_idx_i | input | 4 | Read port B index |
| rb_data_o | output | DATA_W | Read port B data |
| we_i | input | 1 | Write enable, current mode |
| wr_idx_i | input | 4 | Write index, current mode |
| wr_data_i | input | DATA_W | Write data, current mode |
| bwe_i | input | 1 | Banked register write enable |
| bw_mode_i | input | 5 | Target mode for banked writes |
| bw_idx_i | input | 4 | Banked write index |
| bw_data_i | input | DATA_W | Banked write data |
| spsr_rdata_o | output | PSR_W | Saved status of current mode |
| spsr_we_i | input | 1 | Saved-status write enable, current mode |
| spsr_wdata_i | input | PSR_W | Saved-status write data, current mode |
| bw_psr_we_i | input | 1 | Banked saved-status write enable |
| bw_psr_data_i | input | PSR_W | Banked saved-status write data |

## Verification
The assertions check the following on every cycle:
- A write to indices 0 to 7 or to index 15 is read back under any mode on the next cycle.
- Saved-status reads in user and system modes return zero.
- A user-mode saved-status write leaves all five saved-status registers unchanged.
- Every write lands in its physical register, and the banked port has priority.

Only the bench scenarios can show the following:
- That the FIQ copies and the per-mode copies of indices 13 and 14 really are distinct storage.
- That system mode and undefined mode values are mapped as described.
- That a read in the same cycle as a write returns the old value.
- That exception entry can load a link register and a saved-status register in another mode without disturbing the current mode's copies.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int unsigned IDX_W    = 4;
  localparam int unsigned MODE_W   = 5;
  localparam int unsigned PHYS_W   = 5;
  localparam int unsigned NUM_PHYS = 31;  // 15 user, 1 pc, 7 fiq, 4x2 exception
  localparam int unsigned NUM_SLOT = 5;   // saved-status registers

  localparam logic [MODE_W-1:0] MODE_USR = 5'h10;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'h11;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'h12;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'h13;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'h17;
  localparam logic [MODE_W-1:0] MODE_UND = 5'h1B;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'h1F;

  typedef enum logic [2:0] {
    BK_USR = 3'd0, BK_FIQ = 3'd1, BK_SVC = 3'd2,
    BK_ABT = 3'd3, BK_UND = 3'd4, BK_IRQ = 3'd5
  } bank_e;

  function automatic bank_e decode_mode(logic [MODE_W-1:0] m);
    case (m)
      MODE_FIQ: return BK_FIQ;
      MODE_IRQ: return BK_IRQ;
      MODE_SVC: return BK_SVC;
      MODE_ABT: return BK_ABT;
      MODE_UND: return BK_UND;
      default:  return BK_USR;  // user, system and unknown values
    endcase
  endfunction

  // saved-status slot of an exception bank: fiq 0, svc 1, abt 2, und 3, irq 4
  function automatic logic [2:0] psr_slot(bank_e b);
    return 3'(b) - 3'd1;
  endfunction
endpackage

// File: rtl/regbank_map.sv
module regbank_map
  import regbank_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [PHYS_W-1:0] phys_o
);
  bank_e             bank;
  logic [PHYS_W-1:0] i5;
  logic [PHYS_W-1:0] xoff;

  always_comb begin
    bank = decode_mode(mode_i);
    i5   = {1'b0, idx_i};
    case (bank)
      BK_SVC:  xoff = 5'd10;  // 13,14 -> 23,24
      BK_ABT:  xoff = 5'd12;
      BK_UND:  xoff = 5'd14;
      BK_IRQ:  xoff = 5'd16;
      default: xoff = 5'd0;
    endcase
    if (idx_i == 4'd15 || idx_i < 4'd8) begin
      phys_o = i5;                 // shared low registers and pc
    end else if (bank == BK_FIQ) begin
      phys_o = i5 + 5'd8;          // 8..14 -> 16..22
    end else if (idx_i >= 4'd13) begin
      phys_o = i5 + xoff;
    end else begin
      phys_o = i5;
    end
  end
endmodule

// File: rtl/regbank_storage.sv
module regbank_storage #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_PHYS = 31,
  parameter int unsigned PHYS_W   = 5,
  parameter int unsigned NUM_RD   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wa_en_i,
  input  logic [PHYS_W-1:0]   wa_addr_i,
  input  logic [DATA_W-1:0]   wa_data_i,
  input  logic                wb_en_i,
  input  logic [PHYS_W-1:0]   wb_addr_i,
  input  logic [DATA_W-1:0]   wb_data_i,
  input  logic [NUM_RD-1:0][PHYS_W-1:0] rd_addr_i,
  output logic [NUM_RD-1:0][DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] regs [NUM_PHYS];

  for (genvar g = 0; g < NUM_PHYS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs[g] <= '0;
      end else if (wb_en_i && wb_addr_i == PHYS_W'(g)) begin
        regs[g] <= wb_data_i;   // banked port has priority
      end else if (wa_en_i && wa_addr_i == PHYS_W'(g)) begin
        regs[g] <= wa_data_i;
      end
    end
  end

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
    assign rd_data_o[r] = (32'(rd_addr_i[r]) < NUM_PHYS) ? regs[rd_addr_i[r]] : '0;
  end

  // R8: a normal write lands unless the banked port targets the same register
  a_r8_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wa_en_i && !(wb_en_i && wb_addr_i == wa_addr_i))
      |=> regs[$past(wa_addr_i)] == $past(wa_data_i));
  // R9: a banked write always lands
  a_r9_banked_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_i |=> regs[$past(wb_addr_i)] == $past(wb_data_i));
endmodule

// File: rtl/regbank_psr.sv
module regbank_psr
  import regbank_pkg::*;
#(
  parameter int unsigned PSR_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  bank_e            cur_bank_i,
  input  logic             we_i,
  input  logic [PSR_W-1:0] wdata_i,
  input  bank_e            bw_bank_i,
  input  logic             bw_we_i,
  input  logic [PSR_W-1:0] bw_wdata_i,
  output logic [PSR_W-1:0] rdata_o
);
  logic [NUM_SLOT-1:0][PSR_W-1:0] slots;
  logic [2:0] cur_slot, bw_slot;
  logic       cur_ok, bw_ok;

  assign cur_slot = psr_slot(cur_bank_i);
  assign bw_slot  = psr_slot(bw_bank_i);
  assign cur_ok   = (cur_bank_i != BK_USR);
  assign bw_ok    = (bw_bank_i != BK_USR);

  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slots[s] <= '0;
      end else if (bw_we_i && bw_ok && bw_slot == 3'(s)) begin
        slots[s] <= bw_wdata_i;
      end else if (we_i && cur_ok && cur_slot == 3'(s)) begin
        slots[s] <= wdata_i;
      end
    end
  end

  assign rdata_o = cur_ok ? slots[cur_slot] : '0;

  // R7: user/system write through the normal port touches no slot
  a_r7_no_user_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !cur_ok && !bw_we_i) |=> $stable(slots));
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import regbank_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PSR_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [4:0]        mode_i,
  input  logic [3:0]        ra_idx_i,
  output logic [DATA_W-1:0] ra_data_o,
  input  logic [3:0]        rb_idx_i,
  output logic [DATA_W-1:0] rb_data_o,
  input  logic              we_i,
  input  logic [3:0]        wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              bwe_i,
  input  logic [4:0]        bw_mode_i,
  input  logic [3:0]        bw_idx_i,
  input  logic [DATA_W-1:0] bw_data_i,
  output logic [PSR_W-1:0]  spsr_rdata_o,
  input  logic              spsr_we_i,
  input  logic [PSR_W-1:0]  spsr_wdata_i,
  input  logic              bw_psr_we_i,
  input  logic [PSR_W-1:0]  bw_psr_data_i
);
  localparam int unsigned NUM_RD = 2;

  logic [NUM_RD-1:0][IDX_W-1:0]  rd_idx;
  logic [NUM_RD-1:0][PHYS_W-1:0] rd_phys;
  logic [NUM_RD-1:0][DATA_W-1:0] rd_data;
  logic [PHYS_W-1:0] wa_phys, wb_phys;

  assign rd_idx    = {rb_idx_i, ra_idx_i};
  assign ra_data_o = rd_data[0];
  assign rb_data_o = rd_data[1];

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rmap
    regbank_map u_map (.mode_i(mode_i), .idx_i(rd_idx[r]), .phys_o(rd_phys[r]));
  end
  regbank_map u_wmap (.mode_i(mode_i),    .idx_i(wr_idx_i), .phys_o(wa_phys));
  regbank_map u_bmap (.mode_i(bw_mode_i), .idx_i(bw_idx_i), .phys_o(wb_phys));

  regbank_storage #(
    .DATA_W(DATA_W), .NUM_PHYS(NUM_PHYS), .PHYS_W(PHYS_W), .NUM_RD(NUM_RD)
  ) u_store (
    .clk_i, .rst_ni,
    .wa_en_i(we_i),  .wa_addr_i(wa_phys), .wa_data_i(wr_data_i),
    .wb_en_i(bwe_i), .wb_addr_i(wb_phys), .wb_data_i(bw_data_i),
    .rd_addr_i(rd_phys), .rd_data_o(rd_data)
  );

  regbank_psr #(.PSR_W(PSR_W)) u_psr (
    .clk_i, .rst_ni,
    .cur_bank_i(decode_mode(mode_i)), .we_i(spsr_we_i), .wdata_i(spsr_wdata_i),
    .bw_bank_i(decode_mode(bw_mode_i)), .bw_we_i(bw_psr_we_i),
    .bw_wdata_i(bw_psr_data_i), .rdata_o(spsr_rdata_o)
  );

  // R1: low registers read back under any mode after a write
  a_r1_low_shared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !bwe_i && wr_idx_i < 4'd8)
      |=> (ra_idx_i != $past(wr_idx_i)) || (ra_data_o == $past(wr_data_i)));
  // R5: program counter shared across modes
  a_r5_pc_shared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !bwe_i && wr_idx_i == 4'd15)
      |=> (ra_idx_i != 4'd15) || (ra_data_o == $past(wr_data_i)));
  // R7: no saved status visible in user or system mode
  a_r7_zero_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_USR || mode_i == MODE_SYS) |-> spsr_rdata_o == '0);
endmodule

// File: tb/banked_regfile_tb.sv
`timescale 1ns/1ps
module banked_regfile_tb;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned PSR_W  = 32;
  localparam logic [1:0] OP_W = 2'b01, OP_R = 2'b10;
  localparam logic [4:0] M_USR = 5'h10, M_FIQ = 5'h11, M_IRQ = 5'h12, M_SVC = 5'h13,
                         M_ABT = 5'h17, M_UND = 5'h1B, M_SYS = 5'h1F, M_BAD = 5'h05;
  localparam int NV = 29;
  // {op, mode, index, data}; for reads data is the expected value
  localparam logic [42:0] VEC [NV] = '{
    {OP_W, M_USR, 4'd3,  32'h1111_0003},
    {OP_R, M_FIQ, 4'd3,  32'h1111_0003},  // R1
    {OP_R, M_IRQ, 4'd3,  32'h1111_0003},  // R1
    {OP_W, M_SVC, 4'd7,  32'h7777_0013},
    {OP_R, M_SYS, 4'd7,  32'h7777_0013},  // R1
    {OP_W, M_USR, 4'd9,  32'hA9A9_0010},
    {OP_W, M_FIQ, 4'd9,  32'hF9F9_0011},
    {OP_R, M_USR, 4'd9,  32'hA9A9_0010},  // R2
    {OP_R, M_SVC, 4'd9,  32'hA9A9_0010},  // R2
    {OP_R, M_FIQ, 4'd9,  32'hF9F9_0011},  // R2
    {OP_W, M_IRQ, 4'd12, 32'hC12C_0012},
    {OP_R, M_FIQ, 4'd12, 32'h0000_0000},  // R2
    {OP_W, M_USR, 4'd13, 32'h0D00_0010},
    {OP_W, M_SVC, 4'd13, 32'h0D00_0013},
    {OP_W, M_ABT, 4'd13, 32'h0D00_0017},
    {OP_W, M_UND, 4'd13, 32'h0D00_001B},
    {OP_W, M_IRQ, 4'd13, 32'h0D00_0012},
    {OP_W, M_FIQ, 4'd13, 32'h0D00_0011},
    {OP_R, M_SYS, 4'd13, 32'h0D00_0010},  // R3
    {OP_R, M_SVC, 4'd13, 32'h0D00_0013},  // R3
    {OP_R, M_ABT, 4'd13, 32'h0D00_0017},  // R3
    {OP_R, M_UND, 4'd13, 32'h0D00_001B},  // R3
    {OP_R, M_IRQ, 4'd13, 32'h0D00_0012},  // R3
    {OP_R, M_FIQ, 4'd13, 32'h0D00_0011},  // R3
    {OP_W, M_SYS, 4'd14, 32'h0E00_001F},
    {OP_R, M_USR, 4'd14, 32'h0E00_001F},  // R3
    {OP_W, M_BAD, 4'd13, 32'h0D00_00EE},
    {OP_R, M_USR, 4'd13, 32'h0D00_00EE},  // R4
    {OP_W, M_IRQ, 4'd15, 32'h0000_0018}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [4:0] mode_i = M_USR, bw_mode_i = M_USR;
  logic [3:0] ra_idx_i = '0, rb_idx_i = '0, wr_idx_i = '0, bw_idx_i = '0;
  logic we_i = 1'b0, bwe_i = 1'b0, spsr_we_i = 1'b0, bw_psr_we_i = 1'b0;
  logic [DATA_W-1:0] wr_data_i = '0, bw_data_i = '0, ra_data_o, rb_data_o;
  logic [PSR_W-1:0]  spsr_wdata_i = '0, bw_psr_data_i = '0, spsr_rdata_o;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  banked_regfile #(.DATA_W(DATA_W), .PSR_W(PSR_W)) u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] m, logic [3:0] idx, logic [31:0] d);
    @(negedge clk_i);
    mode_i = m; wr_idx_i = idx; wr_data_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(string req, logic [4:0] m, logic [3:0] idx, logic [31:0] exp);
    @(negedge clk_i);
    mode_i = m; ra_idx_i = idx; rb_idx_i = idx;
    #1 chk(req, ra_data_o, exp);
  endtask

  task automatic psr_wr(logic [4:0] m, logic [31:0] d);
    @(negedge clk_i);
    mode_i = m; spsr_wdata_i = d; spsr_we_i = 1'b1;
    @(negedge clk_i);
    spsr_we_i = 1'b0;
  endtask

  task automatic psr_rd(string req, logic [4:0] m, logic [31:0] exp);
    @(negedge clk_i);
    mode_i = m;
    #1 chk(req, spsr_rdata_o, exp);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R10: reset state
    rd("R10", M_USR, 4'd3, 32'h0);
    rd("R10", M_FIQ, 4'd14, 32'h0);
    psr_rd("R10", M_SVC, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][42:41] == OP_W) wr(VEC[i][40:36], VEC[i][35:32], VEC[i][31:0]);
      else rd("R1-3 table", VEC[i][40:36], VEC[i][35:32], VEC[i][31:0]);
    end
    // R5: pc shared
    rd("R5", M_FIQ, 4'd15, 32'h0000_0018);
    rd("R5", M_USR, 4'd15, 32'h0000_0018);
    #1 chk("R5 port B", rb_data_o, 32'h0000_0018);

    // R8: read during write returns old value
    @(negedge clk_i);
    mode_i = M_USR; ra_idx_i = 4'd3;
    we_i = 1'b1; wr_idx_i = 4'd3; wr_data_i = 32'hCAFE_0003;
    #1 chk("R8 old", ra_data_o, 32'h1111_0003);
    @(negedge clk_i);
    we_i = 1'b0;
    #1 chk("R8 new", ra_data_o, 32'hCAFE_0003);

    // R6: per-mode saved status
    psr_wr(M_SVC, 32'h0000_0013);
    psr_wr(M_ABT, 32'h0000_0017);
    psr_rd("R6", M_SVC, 32'h0000_0013);
    psr_rd("R6", M_ABT, 32'h0000_0017);
    psr_rd("R6", M_UND, 32'h0);

    // R7: user/system saved status
    psr_wr(M_USR, 32'hFFFF_FFFF);
    psr_wr(M_SYS, 32'hEEEE_EEEE);
    psr_rd("R7", M_USR, 32'h0);
    psr_rd("R7", M_SYS, 32'h0);
    psr_rd("R7", M_SVC, 32'h0000_0013);
    psr_rd("R7", M_FIQ, 32'h0);
    psr_rd("R7", M_UND, 32'h0);

    // R9: exception entry writes target mode alongside a normal write
    @(negedge clk_i);
    mode_i = M_USR; we_i = 1'b1; wr_idx_i = 4'd14; wr_data_i = 32'h0E10_AAAA;
    bwe_i = 1'b1; bw_mode_i = M_IRQ; bw_idx_i = 4'd14; bw_data_i = 32'h0E12_BBBB;
    bw_psr_we_i = 1'b1; bw_psr_data_i = 32'h0000_00D3;
    @(negedge clk_i);
    we_i = 1'b0; bwe_i = 1'b0; bw_psr_we_i = 1'b0;
    rd("R9", M_IRQ, 4'd14, 32'h0E12_BBBB);
    rd("R9", M_USR, 4'd14, 32'h0E10_AAAA);
    psr_rd("R9", M_IRQ, 32'h0000_00D3);

    // R9: conflict, banked port wins
    @(negedge clk_i);
    mode_i = M_SVC; we_i = 1'b1; wr_idx_i = 4'd13; wr_data_i = 32'h0000_0001;
    bwe_i = 1'b1; bw_mode_i = M_SVC; bw_idx_i = 4'd13; bw_data_i = 32'h0000_0002;
    spsr_we_i = 1'b1; spsr_wdata_i = 32'h5;
    bw_psr_we_i = 1'b1; bw_psr_data_i = 32'h6;
    @(negedge clk_i);
    we_i = 1'b0; bwe_i = 1'b0; spsr_we_i = 1'b0; bw_psr_we_i = 1'b0;
    rd("R9 conflict", M_SVC, 4'd13, 32'h0000_0002);
    psr_rd("R9 conflict", M_SVC, 32'h6);

    // R10: asynchronous reset clears state
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1 mode_i = M_FIQ; ra_idx_i = 4'd9;
    #1 chk("R10 async", ra_data_o, 32'h0);
    chk("R10 async psr", spsr_rdata_o, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    finish_run();
  end
endmodule